// File: doc/BRIEF.md
# Timed Command Scheduler

This block sits between a command source and the configuration port of a pixel front-end chip. Every incoming command word carries a flag that marks it as immediate or timed. Immediate commands are issued to the shift-out side on the next clock edge. Timed commands are written into a pending queue. Each one leaves the queue when it reaches the head and a free-running time counter equals the target time stored in the command. Commands are issued on a parallel strobe, and a serializer outside this block consumes them.

The same counter stamps readout hits as they pass through. Hits leave in the order they arrived, and each carries the counter value from the cycle in which it was presented. Any issued command whose opcode carries the amplitude tag also loads a small register that sets the calibration pulse-injection amplitude. This allows a threshold scan to step the amplitude at precisely scheduled times. If a timed command arrives while the queue is full, the command is discarded and a sticky flag is raised. The flag stays set until it is cleared.

Top module: `cmd_sched`

## Requirements
- R1: `time_now` is 0 in the first cycle after reset. It increases by one every cycle and wraps from its all-ones value to 0 with no other effect.
- R2: The command word is laid out as {timed flag (MSB), target time (TIME_W bits), opcode (OP_W bits, LSBs)}. When a valid word has the flag at 0, `so_valid` is 1 one cycle later, with `so_timed` at 0 and `so_op` equal to the opcode.
- R3: A valid word with the flag at 1 is queued. It is issued with `so_valid`=1 and `so_timed`=1 one cycle after a cycle in which it is at the queue head and its target time equals `time_now`. Its target time can first match in the cycle after the one in which it was accepted.
- R4: Timed commands are issued strictly in arrival order. A head entry whose time has not come holds back every entry behind it.
- R5: If an immediate command arrives in a cycle in which the head entry is due, the immediate command is issued first. The head entry stays due and is issued in the first later cycle that has no immediate command.
- R6: `q_full` is 1 while DEPTH entries are pending. A timed command accepted while `q_full` is 1 is discarded and never issued.
- R7: `ovf` is set by a discarded timed command and holds until `ovf_clr` is 1 in a cycle with no new discard. If a discard and a clear fall in the same cycle, the set wins.
- R8: When an issued command has its two opcode MSBs equal to 2'b11, `amp` takes the opcode's low AMP_W bits in the same cycle that `so_valid` rises. In every other cycle `amp` holds its value.
- R9: One cycle after `hit_valid`, `hit_valid_o` is 1. `hit_data_o` then equals the presented data and `hit_stamp` equals the `time_now` value of the presenting cycle. No reordering takes place.
- R10: During and right after reset, `so_valid`, `amp`, `ovf` and `q_full` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 1+TIME_W+OP_W | {timed flag, target time, opcode} |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| hit_valid | input | 1 | Readout hit present |
| hit_data | input | HIT_W | Readout hit payload |
| so_valid | output | 1 | Command issued to shift-out this cycle |
| so_timed | output | 1 | Issued command came from the queue |
| so_op | output | OP_W | Issued opcode |
| amp | output | AMP_W | Pulse-injection amplitude |
| time_now | output | TIME_W | Free-running time counter |
| q_full | output | 1 | Pending queue full |
| ovf | output | 1 | Sticky dropped-command flag |
| hit_valid_o | output | 1 | Stamped hit present |
| hit_data_o | output | HIT_W | Hit payload, passed through |
| hit_stamp | output | TIME_W | Time of hit arrival |

## Verification
The bench builds the block with TIME_W=6 and DEPTH=4, so the counter wraps every 64 cycles and four pending commands fill the queue. These sizes let a short run drive the queue into overflow, both clear and re-set the sticky flag, and cross several wraps. They also cover a command whose equal target time has already passed, which therefore waits one full lap. Stepping the amplitude needs only OP_W=8, and with it the tagged and untagged opcode cases come from both immediate and timed commands.

// File: rtl/cmd_sched_pkg.sv
package cmd_sched_pkg;

  localparam logic [1:0] AMP_TAG = 2'b11;

  typedef enum logic [1:0] {
    ISS_NONE = 2'd0,
    ISS_IMM  = 2'd1,
    ISS_TMD  = 2'd2
  } iss_e;

  function automatic logic is_amp_op(input logic [1:0] tag);
    return tag == AMP_TAG;
  endfunction

endpackage

// File: rtl/cmd_sched_timebase.sv
module cmd_sched_timebase #(
  parameter int TIME_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  output logic [TIME_W-1:0] now
);

  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end

endmodule

// File: rtl/cmd_sched_fifo.sv
module cmd_sched_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 23
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp, rp_n, wp_n;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wp_n = (wp == LAST) ? '0 : wp + 1'b1;
    rp_n = rp;
    if (do_pop) rp_n = (rp == LAST) ? '0 : rp + 1'b1;
  end

  // storage: no reset, single write port, registered read
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  // read registered on the next read address; write-first bypass
  always_ff @(posedge clk) begin
    if (do_push && (wp == rp_n)) rdata <= wdata;
    else                         rdata <= mem[rp_n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp_n;
      rp <= rp_n;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/cmd_sched_issue.sv
module cmd_sched_issue
  import cmd_sched_pkg::*;
#(
  parameter int TIME_W = 15,
  parameter int OP_W   = 8,
  parameter int AMP_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_timed,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic              head_valid,
  input  logic [TIME_W-1:0] head_time,
  input  logic [OP_W-1:0]   head_op,
  input  logic [TIME_W-1:0] now,
  output logic              pop,
  output logic              so_valid,
  output logic              so_timed,
  output logic [OP_W-1:0]   so_op,
  output logic [AMP_W-1:0]  amp
);

  logic            imm, due, late_q;
  iss_e            src;
  logic [OP_W-1:0] sel_op;

  assign imm = cmd_valid & ~cmd_timed;
  // a head that lost arbitration stays due although the counter moved on
  assign due = head_valid & ((head_time == now) | late_q);
  assign pop = due & ~imm;

  always_comb begin
    if (imm)      src = ISS_IMM;
    else if (due) src = ISS_TMD;
    else          src = ISS_NONE;
    sel_op = (src == ISS_IMM) ? cmd_op : head_op;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      late_q   <= 1'b0;
      so_valid <= 1'b0;
      so_timed <= 1'b0;
      so_op    <= '0;
      amp      <= '0;
    end else begin
      late_q   <= due & imm;
      so_valid <= (src != ISS_NONE);
      so_timed <= (src == ISS_TMD);
      if (src != ISS_NONE) begin
        so_op <= sel_op;
        if (is_amp_op(sel_op[OP_W-1 -: 2])) amp <= sel_op[AMP_W-1:0];
      end
    end
  end

endmodule

// File: rtl/cmd_sched_stamp.sv
module cmd_sched_stamp #(
  parameter int TIME_W = 15,
  parameter int HIT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_valid,
  input  logic [HIT_W-1:0]  hit_data,
  input  logic [TIME_W-1:0] now,
  output logic              hit_valid_o,
  output logic [HIT_W-1:0]  hit_data_o,
  output logic [TIME_W-1:0] hit_stamp
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid_o <= 1'b0;
      hit_data_o  <= '0;
      hit_stamp   <= '0;
    end else begin
      hit_valid_o <= hit_valid;
      if (hit_valid) begin
        hit_data_o <= hit_data;
        hit_stamp  <= now;
      end
    end
  end

endmodule

// File: rtl/cmd_sched.sv
module cmd_sched #(
  parameter int TIME_W = 15,
  parameter int OP_W   = 8,
  parameter int AMP_W  = 6,
  parameter int DEPTH  = 128,
  parameter int HIT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  logic [TIME_W+OP_W:0]     cmd_word,
  input  logic                     ovf_clr,
  input  logic                     hit_valid,
  input  logic [HIT_W-1:0]         hit_data,
  output logic                     so_valid,
  output logic                     so_timed,
  output logic [OP_W-1:0]          so_op,
  output logic [AMP_W-1:0]         amp,
  output logic [TIME_W-1:0]        time_now,
  output logic                     q_full,
  output logic                     ovf,
  output logic                     hit_valid_o,
  output logic [HIT_W-1:0]         hit_data_o,
  output logic [TIME_W-1:0]        hit_stamp
);

  localparam int ENT_W = TIME_W + OP_W;
  localparam int CMD_W = ENT_W + 1;

  logic             cmd_timed, push, pop, q_empty;
  logic [ENT_W-1:0] head;

  assign cmd_timed = cmd_word[CMD_W-1];
  assign push      = cmd_valid & cmd_timed;

  cmd_sched_timebase #(.TIME_W(TIME_W)) u_tb (
    .clk (clk),
    .rst (rst),
    .now (time_now)
  );

  cmd_sched_fifo #(.DEPTH(DEPTH), .DW(ENT_W)) u_q (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (cmd_word[ENT_W-1:0]),
    .pop   (pop),
    .rdata (head),
    .full  (q_full),
    .empty (q_empty)
  );

  cmd_sched_issue #(.TIME_W(TIME_W), .OP_W(OP_W), .AMP_W(AMP_W)) u_iss (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_timed  (cmd_timed),
    .cmd_op     (cmd_word[OP_W-1:0]),
    .head_valid (~q_empty),
    .head_time  (head[ENT_W-1:OP_W]),
    .head_op    (head[OP_W-1:0]),
    .now        (time_now),
    .pop        (pop),
    .so_valid   (so_valid),
    .so_timed   (so_timed),
    .so_op      (so_op),
    .amp        (amp)
  );

  cmd_sched_stamp #(.TIME_W(TIME_W), .HIT_W(HIT_W)) u_st (
    .clk         (clk),
    .rst         (rst),
    .hit_valid   (hit_valid),
    .hit_data    (hit_data),
    .now         (time_now),
    .hit_valid_o (hit_valid_o),
    .hit_data_o  (hit_data_o),
    .hit_stamp   (hit_stamp)
  );

  // sticky drop flag; a new drop outranks a clear
  always_ff @(posedge clk) begin
    if (rst)                 ovf <= 1'b0;
    else if (push && q_full) ovf <= 1'b1;
    else if (ovf_clr)        ovf <= 1'b0;
  end

endmodule

// File: rtl/cmd_sched_chk.sv
module cmd_sched_chk #(
  parameter int TIME_W = 15,
  parameter int OP_W   = 8,
  parameter int AMP_W  = 6,
  parameter int HIT_W  = 24
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_valid,
  input logic [TIME_W+OP_W:0] cmd_word,
  input logic                 ovf_clr,
  input logic                 hit_valid,
  input logic [HIT_W-1:0]     hit_data,
  input logic                 so_valid,
  input logic                 so_timed,
  input logic [OP_W-1:0]      so_op,
  input logic [AMP_W-1:0]     amp,
  input logic [TIME_W-1:0]    time_now,
  input logic                 q_full,
  input logic                 ovf,
  input logic                 hit_valid_o,
  input logic [HIT_W-1:0]     hit_data_o,
  input logic [TIME_W-1:0]    hit_stamp
);

  p_time_step_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> time_now == TIME_W'($past(time_now) + 1'b1));

  p_imm_issue_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_word[TIME_W+OP_W]) |=>
      (so_valid && !so_timed && so_op == $past(cmd_word[OP_W-1:0])));

  p_drop_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[TIME_W+OP_W] && q_full) |=> ovf);

  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  p_amp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !so_valid |-> $stable(amp));

  p_stamp_r9: assert property (@(posedge clk) disable iff (rst)
    hit_valid |=> (hit_valid_o && hit_stamp == $past(time_now)
                   && hit_data_o == $past(hit_data)));

  p_timed_flag_r3: assert property (@(posedge clk) disable iff (rst)
    so_timed |-> so_valid);

endmodule

bind cmd_sched cmd_sched_chk #(
  .TIME_W(TIME_W), .OP_W(OP_W), .AMP_W(AMP_W), .HIT_W(HIT_W)
) u_chk (.*);

// File: tb/sim_cmd_sched.sv
module sim_cmd_sched;

  localparam int TW     = 6;
  localparam int OW     = 8;
  localparam int AW     = 6;
  localparam int DEP    = 4;
  localparam int HW     = 8;
  localparam int PERIOD = 10;
  localparam int TMOD   = 1 << TW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [TW+OW:0]    cmd_word = '0;
  logic              ovf_clr = 1'b0;
  logic              hit_valid = 1'b0;
  logic [HW-1:0]     hit_data = '0;
  logic              so_valid, so_timed, q_full, ovf, hit_valid_o;
  logic [OW-1:0]     so_op;
  logic [AW-1:0]     amp;
  logic [TW-1:0]     time_now, hit_stamp;
  logic [HW-1:0]     hit_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit hits_on = 1;

  always #(PERIOD/2) clk = ~clk;

  cmd_sched #(.TIME_W(TW), .OP_W(OW), .AMP_W(AW), .DEPTH(DEP), .HIT_W(HW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .ovf_clr(ovf_clr), .hit_valid(hit_valid), .hit_data(hit_data),
    .so_valid(so_valid), .so_timed(so_timed), .so_op(so_op), .amp(amp),
    .time_now(time_now), .q_full(q_full), .ovf(ovf),
    .hit_valid_o(hit_valid_o), .hit_data_o(hit_data_o), .hit_stamp(hit_stamp)
  );

  // behavioural reference
  int q_t[$];
  int q_o[$];
  int m_tm, m_op, m_amp, m_hd, m_hs;
  bit m_sv, m_st, m_ovf, m_hv, m_late;

  always @(posedge clk) begin
    if (rst) begin
      m_tm = 0; m_sv = 0; m_st = 0; m_op = 0; m_amp = 0; m_ovf = 0;
      m_hv = 0; m_hd = 0; m_hs = 0; m_late = 0;
      q_t.delete(); q_o.delete();
    end else begin
      bit imm, tmd, due, was_full;
      imm = cmd_valid && !cmd_word[TW+OW];
      tmd = cmd_valid && cmd_word[TW+OW];
      was_full = (q_t.size() == DEP);
      due = (q_t.size() > 0) && ((q_t[0] == m_tm) || m_late);
      m_sv = 0; m_st = 0;
      if (imm) begin
        m_sv = 1; m_op = int'(cmd_word[OW-1:0]);
      end else if (due) begin
        m_sv = 1; m_st = 1; m_op = q_o[0];
        void'(q_t.pop_front()); void'(q_o.pop_front());
      end
      m_late = due && imm;
      if (m_sv && (m_op >> 6) == 3) m_amp = m_op & ((1 << AW) - 1);
      if (tmd) begin
        if (was_full) m_ovf = 1;
        else begin
          q_t.push_back(int'(cmd_word[TW+OW-1:OW]));
          q_o.push_back(int'(cmd_word[OW-1:0]));
        end
      end else if (ovf_clr) m_ovf = 0;
      m_hv = hit_valid;
      if (hit_valid) begin m_hd = int'(hit_data); m_hs = m_tm; end
      m_tm = (m_tm + 1) % TMOD;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(time_now) == m_tm, "R1", "time_now", int'(time_now), m_tm);
      chk(so_valid == m_sv, "R3", "so_valid", so_valid, m_sv);
      if (m_sv) begin
        chk(so_timed == m_st, "R5", "so_timed", so_timed, m_st);
        chk(int'(so_op) == m_op, "R4", "so_op", int'(so_op), m_op);
      end
      chk(int'(amp) == m_amp, "R8", "amp", int'(amp), m_amp);
      chk(ovf == m_ovf, "R7", "ovf", ovf, m_ovf);
      chk(q_full == (q_t.size() == DEP), "R6", "q_full", q_full, q_t.size() == DEP);
      chk(hit_valid_o == m_hv, "R9", "hit_valid_o", hit_valid_o, m_hv);
      if (m_hv) begin
        chk(int'(hit_stamp) == m_hs, "R9", "hit_stamp", int'(hit_stamp), m_hs);
        chk(int'(hit_data_o) == m_hd, "R9", "hit_data_o", int'(hit_data_o), m_hd);
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // hit stream runs in the background, pattern with gaps
  initial begin
    int k = 0;
    @(negedge clk);
    while (!done) begin
      hit_valid = hits_on && (k % 3 != 1);
      hit_data  = HW'(k * 7 + 3);
      k++;
      @(negedge clk);
    end
  end

  task automatic drive(input bit t, input int tm, input int op);
    cmd_valid = 1'b1;
    cmd_word  = {t, TW'(tm), OW'(op)};
  endtask

  task automatic send(input bit t, input int tm, input int op);
    @(negedge clk); drive(t, tm, op);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int T;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(so_valid == 0 && amp == 0 && ovf == 0 && q_full == 0, "R10", "reset outputs",
        {so_valid, ovf, q_full}, 0);
    rst = 1'b0;
    idle(2);
    // R2 and R8: immediate commands, one with the amplitude tag
    send(0, 0, 8'h15);
    send(0, 0, 8'hC5);
    send(0, 0, 8'h42);
    // R3: timed commands with future targets
    @(negedge clk); T = int'(time_now);
    drive(1, (T + 5) % TMOD, 8'h21);
    @(negedge clk); cmd_valid = 0;
    send(1, (T + 9) % TMOD, 8'hE9);
    idle(12);
    // R4: a far head holds back a near follower
    @(negedge clk); T = int'(time_now);
    drive(1, (T + 12) % TMOD, 8'h31);
    @(negedge clk); cmd_valid = 0;
    send(1, (T + 4) % TMOD, 8'h32);
    idle(TMOD + 10);
    // R5: immediate on the due cycle, then another immediate
    @(negedge clk); T = (int'(time_now) + 6) % TMOD;
    drive(1, T, 8'hC9);
    @(negedge clk); cmd_valid = 0;
    while (int'(time_now) != T) @(negedge clk);
    drive(0, 0, 8'h51);
    @(negedge clk); drive(0, 0, 8'h52);
    @(negedge clk); cmd_valid = 0;
    idle(4);
    // R6 and R7: fill the queue, drop two, clear, set again with a clear
    @(negedge clk); T = int'(time_now);
    for (int i = 0; i < DEP + 2; i++) send(1, (T + 30 + i) % TMOD, 8'h60 + i);
    idle(3);
    @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    idle(40);
    @(negedge clk); T = int'(time_now);
    for (int i = 0; i < DEP; i++) send(1, (T + 20) % TMOD, 8'h70 + i);
    @(negedge clk); drive(1, T, 8'h7F); ovf_clr = 1;
    @(negedge clk); cmd_valid = 0; ovf_clr = 0;
    idle(4 * TMOD + 30);
    // R1: wrap with a target just after zero
    while (int'(time_now) != TMOD - 4) @(negedge clk);
    drive(1, 1, 8'hC1);
    @(negedge clk); cmd_valid = 0;
    hits_on = 0;
    idle(10);
    hits_on = 1;
    idle(20);
    done = 1;
    @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

endmodule